// File: doc/BRIEF.md
# Granular Pause Stall Counter

This block is a per-thread pause timer for a processor pipeline. Software asks for a pause of some number of cycles by writing a data word. The block then holds the thread's stall output high for that time. It counts in steps of eight cycles: the requested value is divided by eight and placed in an internal down counter. A three-bit prescaler advances that counter once every eight clocks. The prescaler restarts on every write, so a request always gets whole eight-cycle steps from the moment it lands.

A request below eight still costs one cycle of stall. An incoming disrupting trap ends a pause at once. A fresh write during a pause replaces whatever time was left. When a stall ends, whether because it ran out or because it was aborted, a one-cycle done pulse tells the pipeline that the thread may go on.

Top module: `pause_stall_timer`

## Requirements
- R1: A write of value V with V >= 8 (trap low) sets stall high from the cycle after the write for exactly 8*floor(V/8) cycles, when no further write or trap arrives.
- R2: The eight-cycle step timing restarts on every write: the stall length counts from the latest write, whatever the prescaler phase was before it.
- R3: A write of value V with V < 8 (bits DATA_W-1..3 all zero) sets stall high for exactly one cycle.
- R4: A trap asserted while stall is high drops stall in the next cycle, and done pulses in that same cycle.
- R5: done is high for exactly one cycle: the first cycle in which stall is low after having been high. It is never high at any other time.
- R6: A write while stall is high replaces the remaining time with the new request, which is counted from that write. done does not pulse at the reload.
- R7: When trap and a write arrive in the same cycle, trap wins and the write is discarded. Stall is low in the next cycle.
- R8: A trap while stall is low has no effect: stall stays low and done stays low.
- R9: After reset, stall and done are low until the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for a pause request |
| wr_data | input | DATA_W | Requested pause length in cycles |
| trap | input | 1 | Disrupting trap: aborts any pause in progress |
| stall | output | 1 | Hold the thread while high |
| done | output | 1 | One-cycle pulse when a stall ends |

## Verification
A wrong counter value or a misaligned prescaler shows up at the ports only when the stall ends. It appears as a stall edge one or more eight-cycle steps too early or too late, so an error shows up on the expected falling cycle of each pause. A lost short-request flag shows up in the very next cycle, as a one-cycle request that never stalls. A missing or doubled done pulse shows up at the cycle after the stall edge. A reload or abort that fails to replace the state shows up as a stall that outlives the cycle count predicted from the last write.

// File: rtl/pause_stall_pkg.sv
package pause_stall_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_ABORT = 2'd2
  } pause_cmd_e;

endpackage

// File: rtl/pause_cmd_dec.sv
module pause_cmd_dec
  import pause_stall_pkg::*;
(
  input  logic       wr_en,
  input  logic       trap,
  output pause_cmd_e cmd
);

  // A trap outranks a write arriving in the same cycle.
  always_comb begin
    if (trap)       cmd = CMD_ABORT;
    else if (wr_en) cmd = CMD_LOAD;
    else            cmd = CMD_HOLD;
  end

endmodule

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] phase_d;
  logic             phase_en;

  always_comb begin
    phase_d  = phase_q;
    phase_en = clear | run;
    if (clear)    phase_d = '0;
    else if (run) phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign tick = run & ~clear & (phase_q == {PRE_W{1'b1}});

endmodule

// File: rtl/pause_counter.sv
module pause_counter
  import pause_stall_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pause_cmd_e        cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              busy,
  output logic              stall,
  output logic              stall_nxt
);

  localparam int CNT_W = DATA_W - PRE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;
  logic             short_q;
  logic             short_d;
  logic             cnt_en;

  assign load_val = wr_data[DATA_W-1:PRE_W];

  always_comb begin
    cnt_d   = cnt_q;
    short_d = 1'b0;
    cnt_en  = 1'b0;
    unique case (cmd)
      CMD_ABORT: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      CMD_LOAD: begin
        cnt_d   = load_val;
        short_d = (load_val == '0);
        cnt_en  = 1'b1;
      end
      default: begin
        if (tick) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      short_q <= short_d;
    end
  end

  assign busy      = (cnt_q != '0);
  assign stall     = busy | short_q;
  assign stall_nxt = (cnt_d != '0) | short_d;

endmodule

// File: rtl/pause_stall_timer.sv
module pause_stall_timer
  import pause_stall_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap,
  output logic              stall,
  output logic              done
);

  logic       rst_meta_q;
  logic       rst_sync_q;
  pause_cmd_e cmd;
  logic       tick;
  logic       busy;
  logic       stall_int;
  logic       stall_nxt;
  logic       done_q;
  logic       done_d;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pause_cmd_dec u_dec (
    .wr_en (wr_en),
    .trap  (trap),
    .cmd   (cmd)
  );

  pause_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clear (cmd == CMD_LOAD),
    .run   (busy),
    .tick  (tick)
  );

  pause_counter #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cmd       (cmd),
    .wr_data   (wr_data),
    .tick      (tick),
    .busy      (busy),
    .stall     (stall_int),
    .stall_nxt (stall_nxt)
  );

  assign done_d = stall_int & ~stall_nxt;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign stall = stall_int;
  assign done  = done_q;

endmodule

// File: rtl/pause_stall_timer_chk.sv
module pause_stall_timer_chk #(
  parameter int DATA_W = 64,
  parameter int PRE_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              trap,
  input logic              stall,
  input logic              done
);

  logic small_req;
  assign small_req = (wr_data[DATA_W-1:PRE_W] == '0);

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trap) |=> stall);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trap && !small_req) ##1 (!wr_en && !trap) |=> stall);

  p_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trap && small_req) ##1 !wr_en |=> !stall);

  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !stall);

  p_done_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> done);

  p_done_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!stall && $past(stall)));

  p_idle_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !stall) |=> (!done && !stall));

endmodule

bind pause_stall_timer pause_stall_timer_chk #(
  .DATA_W(DATA_W),
  .PRE_W (PRE_W)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .trap    (trap),
  .stall   (stall),
  .done    (done)
);

// File: tb/pause_stall_timer_tb_top.sv
module pause_stall_timer_tb_top;

  localparam int DATA_W = 64;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              trap;
  logic              stall;
  logic              done;

  int total;
  int bad;
  int rem;
  logic exp_done;
  string tag;

  pause_stall_timer #(.DATA_W(DATA_W), .PRE_W(3)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .trap    (trap),
    .stall   (stall),
    .done    (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int req_len(input logic [DATA_W-1:0] v);
    if (v < 8) return 1;
    return int'(v / 8) * 8;
  endfunction

  // Compare outputs with the model, then apply the next inputs.
  task automatic cycle(input logic w, input logic [DATA_W-1:0] d, input logic t);
    @(negedge clk);
    total++;
    if (stall !== (rem > 0) || done !== exp_done) begin
      bad++;
      $display("FAIL %s: stall=%0b done=%0b expected stall=%0b done=%0b",
               tag, stall, done, (rem > 0), exp_done);
    end
    wr_en   = w;
    wr_data = d;
    trap    = t;
    if (t) begin
      exp_done = (rem > 0);
      rem = 0;
    end else if (w) begin
      exp_done = 1'b0;
      rem = req_len(d);
    end else begin
      exp_done = (rem == 1);
      if (rem > 0) rem--;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, '0, 1'b0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; rem = 0; exp_done = 1'b0;
    wr_en = 1'b0; wr_data = '0; trap = 1'b0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    tag = "R9 reset";
    idle(4);

    tag = "R1 long request";
    cycle(1'b1, 64'd40, 1'b0); idle(45);
    cycle(1'b1, 64'd15, 1'b0); idle(12);

    tag = "R3 short request";
    cycle(1'b1, 64'd5, 1'b0); idle(3);
    cycle(1'b1, 64'd0, 1'b0); idle(3);
    cycle(1'b1, 64'd7, 1'b0); cycle(1'b1, 64'd1, 1'b0); idle(3);

    tag = "R2 prescaler restart";
    cycle(1'b1, 64'd64, 1'b0); idle(5);
    cycle(1'b1, 64'd8, 1'b0); idle(12);

    tag = "R6 reload";
    cycle(1'b1, 64'd80, 1'b0); idle(10);
    cycle(1'b1, 64'd16, 1'b0); idle(3);
    cycle(1'b1, 64'd3, 1'b0); idle(4);

    tag = "R4 trap abort";
    cycle(1'b1, 64'd200, 1'b0); idle(20);
    cycle(1'b0, '0, 1'b1); idle(5);

    tag = "R7 trap beats write";
    cycle(1'b1, 64'd100, 1'b1); idle(3);
    cycle(1'b1, 64'd48, 1'b0); idle(4);
    cycle(1'b1, 64'd100, 1'b1); idle(3);

    tag = "R8 idle trap";
    cycle(1'b0, '0, 1'b1); cycle(1'b0, '0, 1'b1); idle(3);

    tag = "R5 done pulse random R1 R4 R6";
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = $urandom_range(99);
      cycle(r < 5, DATA_W'($urandom_range(300)), r >= 97);
    end
    idle(320);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule